// File: doc/BRIEF.md
# Phase-Lock Loss Monitor with Validity Flag

This block watches two single-cycle edge strobes, one from the reference divider and one from the feedback counter of a frequency synthesizer, and decides whether they still arrive together. When a feedback edge lands too far from its reference edge, or when one side produces two edges with none from the other side between them, a sticky loss-of-lock flag is raised. The flag stays up until software clears it through a write strobe.

A second flag, the validity flag, tells software when a loss-of-lock reading can be trusted. A clear write drops both flags. The validity flag then rises only after two more reference edges, which means one whole reference period has been watched. Software issues a clear, polls until the validity flag reads 1, and only then reads the loss-of-lock flag.

The tolerated distance between paired edges is an input (`match_win`), counted in clock cycles. Status is presented on a registered read word. Writes carry a single command bit.

Top module: `pll_lock_monitor`

## Requirements
- R1: After a synchronous reset, `rd_data` reads all zero (not unlocked, not valid).
- R2: Read layout: `rd_data[1]` is the loss-of-lock flag (1 = unlocked, 0 = locked), `rd_data[2]` is the validity flag, and every other bit, including bit 0 (the write-only clear command), reads 0.
- R3: A reference edge and a feedback edge whose strobes are N cycles apart, in either order, with N <= `match_win`, do not set the loss-of-lock flag (N = 0 means both strobes in the same cycle).
- R4: If the second edge of a pair comes more than `match_win` cycles after the first, in either order, the loss-of-lock flag is set.
- R5: Two reference strobes with no feedback strobe between them, or two feedback strobes with no reference strobe between them, set the loss-of-lock flag.
- R6: Once set, the loss-of-lock flag stays 1 even when later edge pairs are well matched, until a clear write.
- R7: A write (`wr_en` = 1) with `wr_data[0]` = 1 clears both flags. A write with `wr_data[0]` = 0 changes neither flag.
- R8: After a clear write, the validity flag stays 0 through the first reference strobe and becomes 1 on the second.
- R9: A clear write in the same cycle that a detected mismatch would set the loss-of-lock flag wins: the flag reads 0 afterwards.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Peripheral clock |
| rst | input | 1 | Synchronous active-high reset |
| ref_stb | input | 1 | One-cycle strobe at each reference edge |
| fb_stb | input | 1 | One-cycle strobe at each feedback edge |
| match_win | input | CNT_W | Largest tolerated distance between paired edges, in cycles |
| wr_en | input | 1 | Write strobe for the command word |
| wr_data | input | DATA_W | Command word; bit 0 = clear both flags |
| rd_data | output | DATA_W | Status word: bit 1 loss of lock, bit 2 valid |

## Verification
The assertions check on every cycle that the loss-of-lock flag never falls without a clear, that a detected mismatch reaches the flag unless a clear takes priority, that a clear empties both flags, that the validity flag rises only on a reference strobe, and that a repeated edge or an expired window raises a mismatch. Only the bench's scenarios can show that the window boundary is placed exactly (a distance equal to `match_win` passes and one more fails, in both orders), that validity needs the second reference edge and not the first, and that the read layout and write-zero behaviour look right from the ports.

// File: rtl/pll_lock_pkg.sv
package pll_lock_pkg;

  // Pairing state: which side of an edge pair is still outstanding
  typedef enum logic [1:0] {
    PS_IDLE     = 2'd0,
    PS_WAIT_FB  = 2'd1,
    PS_WAIT_REF = 2'd2
  } pair_st_t;

  // Bit positions in the command and status words
  localparam int WR_CLR_BIT    = 0;
  localparam int RD_UNLOCK_BIT = 1;
  localparam int RD_VALID_BIT  = 2;

endpackage

// File: rtl/lock_pair_check.sv
module lock_pair_check
  import pll_lock_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ref_stb,
  input  logic             fb_stb,
  input  logic [CNT_W-1:0] match_win,
  output logic             miss_o
);

  pair_st_t         st_q, st_n;
  logic [CNT_W-1:0] cnt_q, cnt_n;
  logic             miss_n;
  logic             own_stb, other_stb;

  // Strobe of the side already pending, and of the side being awaited
  always_comb begin
    own_stb   = 1'b0;
    other_stb = 1'b0;
    if (st_q == PS_WAIT_FB) begin
      own_stb   = ref_stb;
      other_stb = fb_stb;
    end else if (st_q == PS_WAIT_REF) begin
      own_stb   = fb_stb;
      other_stb = ref_stb;
    end
  end

  always_comb begin
    st_n   = st_q;
    cnt_n  = cnt_q;
    miss_n = 1'b0;
    if (st_q == PS_IDLE) begin
      if (ref_stb && !fb_stb) begin
        st_n  = PS_WAIT_FB;
        cnt_n = CNT_W'(1);
      end else if (fb_stb && !ref_stb) begin
        st_n  = PS_WAIT_REF;
        cnt_n = CNT_W'(1);
      end
    end else begin
      if (other_stb) begin
        // partner arrived: judge the distance
        if (cnt_q > match_win) miss_n = 1'b1;
        if (own_stb) begin
          cnt_n = CNT_W'(1);           // a fresh edge of the same side now waits
        end else begin
          st_n = PS_IDLE;
        end
      end else if (own_stb) begin
        // same side fired twice with nothing from the partner
        miss_n = 1'b1;
        cnt_n  = CNT_W'(1);
      end else if (cnt_q >= match_win) begin
        // window expired
        miss_n = 1'b1;
        st_n   = PS_IDLE;
      end else begin
        cnt_n = cnt_q + CNT_W'(1);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q   <= PS_IDLE;
      cnt_q  <= '0;
      miss_o <= 1'b0;
    end else begin
      st_q   <= st_n;
      cnt_q  <= cnt_n;
      miss_o <= miss_n;
    end
  end

  // R5: a repeated reference edge while one is pending raises a mismatch
  a_r5_repeat_ref: assert property (@(posedge clk) disable iff (rst)
    (st_q == PS_WAIT_FB && ref_stb && !fb_stb) |=> miss_o);

  // R5: a repeated feedback edge while one is pending raises a mismatch
  a_r5_repeat_fb: assert property (@(posedge clk) disable iff (rst)
    (st_q == PS_WAIT_REF && fb_stb && !ref_stb) |=> miss_o);

  // R4: an expired window with no partner raises a mismatch
  a_r4_window_expiry: assert property (@(posedge clk) disable iff (rst)
    (st_q != PS_IDLE && !ref_stb && !fb_stb && cnt_q >= match_win) |=> miss_o);

endmodule

// File: rtl/lock_sticky_flag.sv
module lock_sticky_flag (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic set,
  output logic flag_o
);

  always_ff @(posedge clk) begin
    if (rst) begin
      flag_o <= 1'b0;
    end else if (clr) begin
      flag_o <= 1'b0;                // clear wins over a same-cycle set
    end else if (set) begin
      flag_o <= 1'b1;
    end
  end

  // R6: the flag never falls without a clear
  a_r6_sticky: assert property (@(posedge clk) disable iff (rst)
    (flag_o && !clr) |=> flag_o);

  // R4: a mismatch reaches the flag unless a clear is present
  a_r4_set_reaches_flag: assert property (@(posedge clk) disable iff (rst)
    (set && !clr) |=> flag_o);

  // R9: a clear empties the flag even with a set in the same cycle
  a_r9_clear_priority: assert property (@(posedge clk) disable iff (rst)
    clr |=> !flag_o);

endmodule

// File: rtl/lock_valid_gate.sv
module lock_valid_gate #(
  parameter int ARM_EDGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic ref_stb,
  output logic valid_o
);

  localparam int AW = $clog2(ARM_EDGES + 1);
  localparam logic [AW-1:0] LAST = AW'(ARM_EDGES - 1);
  localparam logic [AW-1:0] FULL = AW'(ARM_EDGES);

  logic [AW-1:0] seen_q;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      seen_q  <= '0;
      valid_o <= 1'b0;
    end else if (ref_stb && seen_q != FULL) begin
      seen_q <= seen_q + AW'(1);
      if (seen_q == LAST) valid_o <= 1'b1;
    end
  end

  // R8: the validity flag can only rise on a reference strobe
  a_r8_rise_on_ref: assert property (@(posedge clk) disable iff (rst)
    (!valid_o && !ref_stb) |=> !valid_o);

  // R7: a clear drops the validity flag
  a_r7_clear_valid: assert property (@(posedge clk) disable iff (rst)
    clr |=> !valid_o);

endmodule

// File: rtl/pll_lock_monitor.sv
module pll_lock_monitor
  import pll_lock_pkg::*;
#(
  parameter int CNT_W     = 8,
  parameter int DATA_W    = 8,
  parameter int ARM_EDGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ref_stb,
  input  logic              fb_stb,
  input  logic [CNT_W-1:0]  match_win,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] rd_data
);

  logic clr_cmd;
  logic miss;
  logic unlock_q;
  logic valid_q;

  assign clr_cmd = wr_en && wr_data[WR_CLR_BIT];

  lock_pair_check #(.CNT_W(CNT_W)) u_pair (
    .clk       (clk),
    .rst       (rst),
    .ref_stb   (ref_stb),
    .fb_stb    (fb_stb),
    .match_win (match_win),
    .miss_o    (miss)
  );

  lock_sticky_flag u_unlock (
    .clk    (clk),
    .rst    (rst),
    .clr    (clr_cmd),
    .set    (miss),
    .flag_o (unlock_q)
  );

  lock_valid_gate #(.ARM_EDGES(ARM_EDGES)) u_valid (
    .clk     (clk),
    .rst     (rst),
    .clr     (clr_cmd),
    .ref_stb (ref_stb),
    .valid_o (valid_q)
  );

  // Status word built straight from flops; the clear bit is write-only
  always_comb begin
    rd_data                = '0;
    rd_data[RD_UNLOCK_BIT] = unlock_q;
    rd_data[RD_VALID_BIT]  = valid_q;
  end

  // R1: both flags are empty in the cycle after reset
  a_r1_reset_empty: assert property (@(posedge clk)
    rst |=> (rd_data == '0));

endmodule

// File: tb/tb_pll_lock_monitor.sv
module tb_pll_lock_monitor;

  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 10;

  typedef struct packed {
    logic       ref_first;
    logic [7:0] gap;
    logic [7:0] win;
    logic       exp_unlock;
  } vec_t;

  // R3 / R4 boundary vectors: order, distance, window, expected loss-of-lock
  localparam vec_t VECS [NVEC] = '{
    '{1'b1, 8'd0,  8'd0,  1'b0},
    '{1'b1, 8'd3,  8'd3,  1'b0},
    '{1'b1, 8'd4,  8'd3,  1'b1},
    '{1'b0, 8'd3,  8'd3,  1'b0},
    '{1'b0, 8'd4,  8'd3,  1'b1},
    '{1'b1, 8'd10, 8'd15, 1'b0},
    '{1'b0, 8'd15, 8'd15, 1'b0},
    '{1'b1, 8'd16, 8'd15, 1'b1},
    '{1'b1, 8'd1,  8'd0,  1'b1},
    '{1'b0, 8'd0,  8'd5,  1'b0}
  };

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       ref_stb = 1'b0;
  logic       fb_stb = 1'b0;
  logic [7:0] match_win = 8'd4;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = 8'd0;
  logic [7:0] rd_data;

  int n_checks = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pll_lock_monitor dut (
    .clk       (clk),
    .rst       (rst),
    .ref_stb   (ref_stb),
    .fb_stb    (fb_stb),
    .match_win (match_win),
    .wr_en     (wr_en),
    .wr_data   (wr_data),
    .rd_data   (rd_data)
  );

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic write_cmd(input logic [7:0] d);
    wr_en = 1'b1; wr_data = d;
    tick(1);
    wr_en = 1'b0; wr_data = 8'd0;
  endtask

  task automatic one_ref;
    ref_stb = 1'b1; tick(1); ref_stb = 1'b0;
  endtask

  task automatic one_fb;
    fb_stb = 1'b1; tick(1); fb_stb = 1'b0;
  endtask

  task automatic edge_pair(input logic ref_first, input int gap);
    if (gap == 0) begin
      ref_stb = 1'b1; fb_stb = 1'b1; tick(1);
      ref_stb = 1'b0; fb_stb = 1'b0;
    end else begin
      if (ref_first) one_ref; else one_fb;
      if (gap > 1) tick(gap - 1);
      if (ref_first) one_fb; else one_ref;
    end
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual running expected finished");
    finish_run();
  end

  initial begin
    tick(4);
    check("R1 reset state", rd_data, 8'h00);
    rst = 1'b0;
    tick(2);
    check("R1 idle after reset", rd_data, 8'h00);

    // Table walk: R3 / R4
    for (int i = 0; i < NVEC; i++) begin
      match_win = VECS[i].win;
      tick(40);
      write_cmd(8'h01);
      tick(2);
      for (int k = 0; k < 3; k++) begin
        edge_pair(VECS[i].ref_first, int'(VECS[i].gap));
        tick(30);
      end
      check(VECS[i].exp_unlock ? "R4 late partner flags" : "R3 in-window pair",
            {7'd0, rd_data[1]}, {7'd0, VECS[i].exp_unlock});
      check("R8 valid after reference edges", {7'd0, rd_data[2]}, 8'd1);
    end

    // R2 layout and R7 clear
    match_win = 8'd2;
    tick(20);
    write_cmd(8'h01);
    one_ref; tick(3); one_ref; tick(10);
    check("R2 layout with unlock and valid", rd_data, 8'h06);
    write_cmd(8'h01);
    tick(2);
    check("R7 clear empties both flags", rd_data, 8'h00);

    // R5: repeated reference, repeated feedback
    match_win = 8'd15;
    tick(30);
    write_cmd(8'h01);
    one_ref; tick(2); one_ref; tick(3);
    check("R5 double reference", {7'd0, rd_data[1]}, 8'd1);
    tick(30);
    write_cmd(8'h01);
    tick(2);
    one_fb; tick(2); one_fb; tick(3);
    check("R5 double feedback", {7'd0, rd_data[1]}, 8'd1);

    // R6 sticky through clean pairs
    for (int k = 0; k < 3; k++) begin
      edge_pair(1'b1, 1);
      tick(25);
    end
    check("R6 unlock held after relock", {7'd0, rd_data[1]}, 8'd1);

    // R7 write with clear bit 0 does nothing
    write_cmd(8'hFE);
    tick(2);
    check("R7 write without clear bit", {7'd0, rd_data[1]}, 8'd1);

    // R8 validity needs the second reference edge
    write_cmd(8'h01);
    tick(3);
    check("R8 not valid before any reference", {7'd0, rd_data[2]}, 8'd0);
    edge_pair(1'b1, 0);
    tick(5);
    check("R8 not valid after first reference", {7'd0, rd_data[2]}, 8'd0);
    edge_pair(1'b1, 0);
    tick(3);
    check("R8 valid after second reference", {7'd0, rd_data[2]}, 8'd1);
    check("R3 matched pairs leave lock", {7'd0, rd_data[1]}, 8'd0);

    // R9: clear lands in the cycle the mismatch would set the flag
    match_win = 8'd2;
    tick(20);
    write_cmd(8'h01);
    tick(2);
    ref_stb = 1'b1; tick(1); ref_stb = 1'b0;   // sampled at edge P0
    tick(2);                                   // edges P1, P2: expiry at P2
    write_cmd(8'h01);                          // sampled at P3, with the set
    tick(3);
    check("R9 clear beats same-cycle set", {7'd0, rd_data[1]}, 8'd0);

    finish_run();
  end

endmodule